// File: doc/BRIEF.md
# Serial Command Sender for a Dual 8-bit DAC

This block sits on the host side of a three-wire serial link to a dual-channel, 8-bit, voltage-output DAC. A request arrives on a ready/valid port. It carries a channel mask, a power-down flag, an update flag, a deferred-load flag and an 8-bit code. The block packs these fields into a 16-bit command word and shifts it out most significant bit first, in SPI mode 0. A programmable divider sets the serial clock. The word is framed by an active-low chip select.

When the deferred-load flag is set, the block waits a fixed gap after chip select has risen. It then drives the separate active-low load strobe low for a timed width and releases it. A one-cycle done pulse marks the end of each transaction. A new request is taken only once chip select has stayed high for the programmed recovery time. Every timing value is a parameter counted in system clock cycles.

Top module: `dac_cmd_sender`

## Requirements
- R1: During and after reset, and before any request, cs_n=1, ldac_n=1, sclk=0, sdo=0, done=0 and req_ready=1.
- R2: The transmitted word is, from bit 15 down to bit 0: three zero bits, power-down (bit 12), update (bit 11), deferred load (bit 10), channel B select = req_chan[1] (bit 9), channel A select = req_chan[0] (bit 8), then the code, bits 7..0. It is sent MSB first. Example: channel A, update, code 0x80 gives 0x0980.
- R3: sdo changes only while sclk is low. It is stable during every sclk high phase, so the receiver samples on sclk rising edges.
- R4: Every sclk high phase and every sclk low phase between rising edges lasts exactly HALF_CYC clock cycles. sclk is low whenever cs_n is high.
- R5: Each frame holds exactly 16 sclk rising edges while cs_n is low.
- R6: Between two frames, cs_n stays high for at least CS_GAP_CYC cycles.
- R7: For a deferred request, ldac_n falls exactly LOAD_GAP_CYC cycles after cs_n rises and stays low exactly LOAD_LOW_CYC cycles. ldac_n is never low while cs_n is low, and it stays high for requests without the deferred flag.
- R8: req_ready is high only when the block is idle. A request is taken on the cycle where req_valid and req_ready are both high, using the field values of that cycle. Field values presented while req_ready is low have no effect, and each handshake yields exactly one frame.
- R9: done is a single-cycle pulse. It is high in the first cycle cs_n is high for a request without deferral, or in the first cycle ldac_n is high again for a deferred request, and at no other time.
- R10: After cs_n falls, sclk stays low for HALF_CYC cycles before its first rise. After the last fall, sclk stays low for at least HALF_CYC cycles before cs_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_chan | input | 2 | Channel mask: bit 0 channel A, bit 1 channel B |
| req_pwrdn | input | 1 | Power down the selected channels |
| req_update | input | 1 | Enable DAC-register update |
| req_defer | input | 1 | Update on the load strobe instead of chip-select rise |
| req_data | input | 8 | DAC code |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data to the DAC |
| cs_n | output | 1 | Active-low chip select |
| ldac_n | output | 1 | Active-low asynchronous load strobe |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The two functions that can meet in one cycle are the end of a transaction, where done fires as cs_n or ldac_n rises, and the acceptance of the next request. The bench provokes this by queuing requests back to back with req_valid held, including one that changes its fields while req_ready is still low. A reference model in the bench measures every phase, gap and pulse width against the parameters and decodes each frame at the sclk rising edges. On the cycle of each rising edge it checks that done matches the rising edge and that the next frame's chip select waits out the full recovery time.

// File: rtl/dac_cmd_pkg.sv
// Shared widths, request layout and sequencer states for the DAC command sender.
package dac_cmd_pkg;
    localparam int unsigned CODE_W  = 8;
    localparam int unsigned CHAN_N  = 2;
    localparam int unsigned CTRL_W  = 3;
    localparam int unsigned FRAME_W = 16;
    localparam int unsigned PAD_W   = FRAME_W - CTRL_W - CHAN_N - CODE_W;

    typedef struct packed {
        logic              pwrdn;
        logic              update;
        logic              defer;
        logic [CHAN_N-1:0] chan;
        logic [CODE_W-1:0] data;
    } dac_req_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_TAIL,
        ST_GAP,
        ST_LOW,
        ST_RECOV
    } seq_state_t;
endpackage

// File: rtl/dac_word_pack.sv
// Packs a request into the 16-bit command word.
// Assumes: pad bits go out as zero; field order is fixed by the receiver's decoder.
module dac_word_pack
    import dac_cmd_pkg::*;
(
    input  dac_req_t           req,
    output logic [FRAME_W-1:0] word
);
    // Concatenate pad, control, address and code fields.
    always_comb begin
        word = {{PAD_W{1'b0}}, req.pwrdn, req.update, req.defer, req.chan, req.data};
    end
endmodule

// File: rtl/dac_bit_shifter.sv
// Shifts one word out MSB first in SPI mode 0 with a divided serial clock.
// Assumes: start is pulsed only while busy is low; HALF_CYC >= 1.
module dac_bit_shifter #(
    parameter int unsigned HALF_CYC = 13,
    parameter int unsigned WORD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              sdo,
    output logic              busy,
    output logic              fin
);
    localparam int unsigned PH_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int unsigned BIT_W = $clog2(WORD_W);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HALF_CYC - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sr;
    logic [PH_W-1:0]   ph;
    logic [BIT_W-1:0]  bit_idx;

    // Phase counting, clock toggling and bit advance on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '0;
            ph      <= '0;
            bit_idx <= '0;
            sclk    <= 1'b0;
            busy    <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                sr      <= word;
                ph      <= '0;
                bit_idx <= '0;
                sclk    <= 1'b0;
                busy    <= 1'b1;
            end else if (busy) begin
                if (ph == PH_LAST) begin
                    ph <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                    end else begin
                        sclk <= 1'b0;
                        if (bit_idx == BIT_LAST) begin
                            busy <= 1'b0;
                            fin  <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            sr      <= {sr[WORD_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    ph <= ph + 1'b1;
                end
            end
        end
    end

    // Serial data is the head of the shift register.
    always_comb sdo = sr[WORD_W-1];
endmodule

// File: rtl/dac_cycle_timer.sv
// Down-counter for the tail, load-gap, load-width and recovery intervals.
// Assumes: loading N-1 gives a state that lasts N cycles.
module dac_cycle_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load, or count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Expiry flag.
    always_comb zero = (cnt == '0);
endmodule

// File: rtl/dac_cmd_sender.sv
// Top: request handshake, chip-select framing, deferred load strobe and done pulse.
// Assumes: all timing parameters are >= 1 and given in system clock cycles.
module dac_cmd_sender
    import dac_cmd_pkg::*;
#(
    parameter int unsigned HALF_CYC     = 13,
    parameter int unsigned CS_GAP_CYC   = 10,
    parameter int unsigned LOAD_GAP_CYC = 2,
    parameter int unsigned LOAD_LOW_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CHAN_N-1:0] req_chan,
    input  logic              req_pwrdn,
    input  logic              req_update,
    input  logic              req_defer,
    input  logic [CODE_W-1:0] req_data,
    output logic              sclk,
    output logic              sdo,
    output logic              cs_n,
    output logic              ldac_n,
    output logic              done
);
    localparam int unsigned T_A   = (HALF_CYC > CS_GAP_CYC) ? HALF_CYC : CS_GAP_CYC;
    localparam int unsigned T_B   = (LOAD_GAP_CYC > LOAD_LOW_CYC) ? LOAD_GAP_CYC : LOAD_LOW_CYC;
    localparam int unsigned T_MAX = (T_A > T_B) ? T_A : T_B;
    localparam int unsigned CNT_W = $clog2(T_MAX + 1);

    seq_state_t         state;
    dac_req_t           req;
    logic [FRAME_W-1:0] word;
    logic               start;
    logic               sh_busy;
    logic               sh_fin;
    logic               defer_q;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;

    // Gather request fields into the packed request type.
    always_comb begin
        req.pwrdn  = req_pwrdn;
        req.update = req_update;
        req.defer  = req_defer;
        req.chan   = req_chan;
        req.data   = req_data;
    end

    dac_word_pack u_pack (
        .req  (req),
        .word (word)
    );

    // Handshake: take requests only when idle.
    always_comb begin
        req_ready = (state == ST_IDLE);
        start     = req_valid && req_ready;
    end

    dac_bit_shifter #(
        .HALF_CYC (HALF_CYC),
        .WORD_W   (FRAME_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .word  (word),
        .sclk  (sclk),
        .sdo   (sdo),
        .busy  (sh_busy),
        .fin   (sh_fin)
    );

    // Choose the interval to load on each state exit.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_XFER: begin
                tmr_load = sh_fin;
                tmr_val  = CNT_W'(HALF_CYC - 1);
            end
            ST_TAIL: begin
                tmr_load = tmr_zero;
                tmr_val  = defer_q ? CNT_W'(LOAD_GAP_CYC - 1) : CNT_W'(CS_GAP_CYC - 1);
            end
            ST_GAP: begin
                tmr_load = tmr_zero;
                tmr_val  = CNT_W'(LOAD_LOW_CYC - 1);
            end
            ST_LOW: begin
                tmr_load = tmr_zero;
                tmr_val  = CNT_W'(CS_GAP_CYC - 1);
            end
            default: begin
                tmr_load = 1'b0;
                tmr_val  = '0;
            end
        endcase
    end

    dac_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Transaction sequencer driving chip select, load strobe and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cs_n    <= 1'b1;
            ldac_n  <= 1'b1;
            done    <= 1'b0;
            defer_q <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    cs_n    <= 1'b0;
                    defer_q <= req_defer;
                    state   <= ST_XFER;
                end
                ST_XFER: if (sh_fin) state <= ST_TAIL;
                ST_TAIL: if (tmr_zero) begin
                    cs_n <= 1'b1;
                    if (defer_q) begin
                        state <= ST_GAP;
                    end else begin
                        done  <= 1'b1;
                        state <= ST_RECOV;
                    end
                end
                ST_GAP: if (tmr_zero) begin
                    ldac_n <= 1'b0;
                    state  <= ST_LOW;
                end
                ST_LOW: if (tmr_zero) begin
                    ldac_n <= 1'b1;
                    done   <= 1'b1;
                    state  <= ST_RECOV;
                end
                ST_RECOV: if (tmr_zero) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dac_cmd_sender_chk.sv
// Protocol checker for dac_cmd_sender, attached by bind.
module dac_cmd_sender_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic sclk,
    input logic sdo,
    input logic cs_n,
    input logic ldac_n,
    input logic done
);
    p_sdo_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));
    p_idle_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    p_ldac_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n |-> cs_n);
    p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && ldac_n));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_cs_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk);
endmodule

bind dac_cmd_sender dac_cmd_sender_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .sclk      (sclk),
    .sdo       (sdo),
    .cs_n      (cs_n),
    .ldac_n    (ldac_n),
    .done      (done)
);

// File: tb/dac_cmd_sender_tb.sv
module dac_cmd_sender_tb;
    localparam int HALF = 13;
    localparam int CSG  = 10;
    localparam int LGAP = 2;
    localparam int LLOW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_chan = '0;
    logic req_pwrdn = 1'b0, req_update = 1'b0, req_defer = 1'b0;
    logic [7:0] req_data = '0;
    logic sclk, sdo, cs_n, ldac_n, done;

    int checks = 0;
    int failures = 0;
    int sent = 0;
    int seen = 0;
    logic [16:0] exp_q[$];

    always #2 clk = ~clk;

    dac_cmd_sender #(
        .HALF_CYC(HALF), .CS_GAP_CYC(CSG), .LOAD_GAP_CYC(LGAP), .LOAD_LOW_CYC(LLOW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_pwrdn(req_pwrdn), .req_update(req_update),
        .req_defer(req_defer), .req_data(req_data), .sclk(sclk), .sdo(sdo),
        .cs_n(cs_n), .ldac_n(ldac_n), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected word built from the R2 field layout.
    function automatic logic [15:0] mk_word(input logic [1:0] ch, input logic pd,
                                            input logic up, input logic df, input logic [7:0] d);
        return {3'b000, pd, up, df, ch[1], ch[0], d};
    endfunction

    task automatic send(input logic [1:0] ch, input logic pd, input logic up,
                        input logic df, input logic [7:0] d);
        @(negedge clk);
        req_chan = ch; req_pwrdn = pd; req_update = up; req_defer = df; req_data = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        exp_q.push_back({df, mk_word(ch, pd, up, df, d)});
        sent++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Fields that change while req_ready is low must not be used (R8).
    task automatic send_late(input logic [1:0] ch, input logic pd, input logic up,
                             input logic df, input logic [7:0] d);
        @(negedge clk);
        req_chan = 2'b11; req_pwrdn = 1'b1; req_update = 1'b0; req_defer = 1'b0; req_data = 8'hC3;
        req_valid = 1'b1;
        @(negedge clk);
        req_chan = ch; req_pwrdn = pd; req_update = up; req_defer = df; req_data = d;
        while (!req_ready) @(negedge clk);
        exp_q.push_back({df, mk_word(ch, pd, up, df, d)});
        sent++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Behavioural slave model and timing monitor, evaluated every clock.
    logic p_sclk = 1'b0, p_cs = 1'b1, p_ldac = 1'b1, p_sdo = 1'b0;
    int run = 0, bits = 0, cs_hi = 0, lo = 0;
    bit defer_pend = 0, first_frame = 1;
    logic [15:0] rx = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_done;
            logic [16:0] item;
            exp_done = 1'b0;
            if (cs_n && sclk) check(0, "R4 sclk high while cs_n high", 1, 0);
            if (sclk && p_sclk && sdo !== p_sdo) check(0, "R3 sdo moved during high phase", sdo, p_sdo);
            if (!ldac_n && !cs_n) check(0, "R7 ldac_n low with cs_n low", 0, 1);
            if (p_cs && !cs_n) begin
                if (!first_frame) check(cs_hi >= CSG, "R6 cs_n high gap", cs_hi, CSG);
                first_frame = 0;
                run = 1; bits = 0; rx = '0;
            end else if (!cs_n) begin
                if (sclk !== p_sclk) begin
                    if (sclk) begin
                        check(run == HALF, (bits == 0) ? "R10 low before first rise" : "R4 low phase",
                              run, HALF);
                        rx = {rx[14:0], sdo};
                        bits++;
                    end else begin
                        check(run == HALF, "R4 high phase", run, HALF);
                    end
                    run = 1;
                end else begin
                    run++;
                end
            end else if (!p_cs && cs_n) begin
                check(run >= HALF, "R10 low before cs_n rise", run, HALF);
                check(bits == 16, "R5 rising edges per frame", bits, 16);
                if (exp_q.size() == 0) begin
                    check(0, "R8 frame without handshake", rx, 0);
                    defer_pend = 0;
                end else begin
                    item = exp_q.pop_front();
                    check(rx == item[15:0], "R2 R8 decoded word", rx, item[15:0]);
                    defer_pend = item[16];
                end
                seen++;
                if (!defer_pend) exp_done = 1'b1;
                cs_hi = 1;
            end else begin
                if (ldac_n) cs_hi++;
            end
            if (p_ldac && !ldac_n) begin
                check(defer_pend, "R7 ldac_n pulse without deferral", 1, defer_pend);
                check(cs_hi == LGAP, "R7 gap cs_n rise to ldac_n fall", cs_hi, LGAP);
                lo = 1;
            end else if (!ldac_n) begin
                lo++;
            end else if (!p_ldac && ldac_n) begin
                check(lo == LLOW, "R7 ldac_n low width", lo, LLOW);
                exp_done = 1'b1;
                defer_pend = 0;
                cs_hi = 1;
            end
            if (exp_done) check(done === 1'b1, "R9 done at end of transaction", done, 1);
            else if (done !== 1'b0) check(0, "R9 stray done", done, 0);
            p_sclk = sclk; p_cs = cs_n; p_ldac = ldac_n; p_sdo = sdo;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n === 1 && ldac_n === 1 && sclk === 0 && sdo === 0 && done === 0 && req_ready === 1,
              "R1 outputs in reset", {cs_n, ldac_n, sclk, sdo, done, req_ready}, 6'b110001);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n === 1 && ldac_n === 1 && sclk === 0 && sdo === 0 && done === 0 && req_ready === 1,
              "R1 outputs after reset", {cs_n, ldac_n, sclk, sdo, done, req_ready}, 6'b110001);
        // R2: channel A, update, code 0x80 gives 0x0980.
        send(2'b01, 1'b0, 1'b1, 1'b0, 8'h80);
        // R7: deferred load on both channels with power-down.
        send(2'b11, 1'b1, 1'b1, 1'b1, 8'h5A);
        // Input-register-only write to channel B.
        send(2'b10, 1'b0, 1'b0, 1'b0, 8'hFF);
        // Update-only with deferral, zero code.
        send(2'b00, 1'b0, 1'b1, 1'b1, 8'h00);
        // R8: fields change while waiting for req_ready.
        send_late(2'b01, 1'b0, 1'b1, 1'b1, 8'hA5);
        // R6, R9: back-to-back requests meeting the end of the previous transaction.
        send(2'b10, 1'b1, 1'b0, 1'b0, 8'h01);
        send(2'b11, 1'b0, 1'b1, 1'b0, 8'h7E);
        repeat (1500) @(negedge clk);
        check(seen == sent, "R8 one frame per handshake", seen, sent);
        check(exp_q.size() == 0, "R8 no pending frames", exp_q.size(), 0);
        check(req_ready === 1 && cs_n === 1 && ldac_n === 1 && sclk === 0, "R1 idle after traffic",
              {req_ready, cs_n, ldac_n, sclk}, 4'b1110);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule